// File: doc/BRIEF.md
# I2C Master Bit Engine

This block is the lowest layer of an I2C master. It produces a start condition, a stop condition, a full written byte with its acknowledge slot, or a full read byte with the master's acknowledge reply. It drives SCL and SDA only through open-drain output enables, where an enable of 1 pulls the line low and an enable of 0 releases it. It reads the real level of each line back from the pin inputs. The timing is set by a delay count D. A slave may hold SCL low to stretch the clock, and the engine waits for it only up to a programmable limit.

A sequencer above this block issues one command at a time while `idle` is high. It reads the result when `done` pulses. The result is the sampled byte, the level seen in the ninth bit slot, and a flag that reports a start attempt made while another device held SDA low. Address framing, repeated transfers and arbitration belong to that sequencer and are not part of this block. SCL and SDA inputs are assumed already synchronised to `clk`, and D and the stretch limit are held steady while a command runs.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset both line enables are 0 (lines released), `idle` is 1, and `done`, `bus_busy` and `stretch_tmo` are 0.
- R2: Command code 2'b00 (start) releases both lines and then samples SDA. If SDA reads low, `bus_busy` is set, both lines stay released, and `done` pulses on the second rising edge after the accepting edge. Otherwise SDA is pulled low after max(D,1) cycles and `done` pulses on rising edge 2D+2 after acceptance (for D≥1), leaving SCL high and SDA low.
- R3: Command code 2'b10 (write) sends `cmd_wdata` MSB first. It pulls SCL low for max(D+1,1) cycles on each data bit with SDA set before SCL is released. The ninth slot releases SDA with a low phase of D+2 cycles. `ack_level` returns the SDA level sampled in that slot, where 0 means the slave acknowledged.
- R4: Command code 2'b11 (read) releases SDA for eight bits, each with an SCL low phase of D+2 cycles, and assembles `rx_data` MSB first. In the ninth slot it pulls SDA low when `cmd_nack` is 0 and releases it when `cmd_nack` is 1, with a low phase of D+1 cycles. `ack_level` reports the level on the line in that slot.
- R5: After a write, `rx_data` holds the eight SDA levels sampled on the line, so a bit that another device forced low reads back as 0.
- R6: Command code 2'b01 (stop) pulls both lines low, releases SCL, then releases SDA after SCL is high. It ends with both lines released, and `done` pulses on rising edge 3D+1 after acceptance when there is no stretching.
- R7: After each SCL release the engine waits while SCL reads low. A stretch that ends before the limit delays completion by its length and does not set `stretch_tmo`.
- R8: If SCL is still low after limit+1 polling cycles, the engine proceeds anyway and sets `stretch_tmo`. The flag stays set until reset.
- R9: `done` is a one-cycle pulse that coincides with `idle`. A command presented while `idle` is 0 is ignored and produces no extra `done`.
- R10: `bus_busy` is cleared only when a new start command is accepted. Other commands leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present; taken only while idle |
| cmd_op | input | 2 | 00 start, 01 stop, 10 write byte, 11 read byte |
| cmd_wdata | input | DW | Byte to write |
| cmd_nack | input | 1 | Read only: 1 leaves the ninth slot released |
| quarter_dly | input | DLY_W | Base delay count D in clock cycles |
| stretch_limit | input | STR_W | Maximum extra cycles spent waiting on a held SCL |
| scl_in | input | 1 | Sampled SCL level |
| sda_in | input | 1 | Sampled SDA level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| idle | output | 1 | Ready for a command |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | DW | Byte sampled in the last byte command |
| ack_level | output | 1 | SDA level in the ninth slot |
| bus_busy | output | 1 | Last start found SDA low |
| stretch_tmo | output | 1 | Sticky: a stretch wait hit its limit |

## Verification
A wrong sequencer state shows at the pins within one bit period. It appears as an SCL low phase of the wrong length, an SDA change while SCL is high inside a byte, or a `done` pulse that arrives early, late or twice. The bench measures every SCL low phase, so a wrong offset or a miscounted bit is caught as soon as the byte finishes. The exact completion latency of each start and stop exposes a wrong delay or a stretch wait that ends at the wrong time. A fault in the sampling path shows up in `rx_data` or `ack_level` when the next `done` arrives.

// File: rtl/i2c_eng_pkg.sv
// Shared types for the I2C master bit engine.
package i2c_eng_pkg;

    // Command codes as seen on cmd_op.
    typedef enum logic [1:0] {
        OP_START = 2'b00,
        OP_STOP  = 2'b01,
        OP_WRITE = 2'b10,
        OP_READ  = 2'b11
    } op_e;

    // Sequencer states: S_* start, B_* byte bit, P_* stop.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_S_REL,
        ST_S_CHK,
        ST_S_HOLD,
        ST_S_FALL,
        ST_B_LOW,
        ST_B_POLL,
        ST_B_HIGH,
        ST_P_LOW,
        ST_P_POLL,
        ST_P_HOLD,
        ST_P_REL
    } state_e;

endpackage

// File: rtl/i2c_eng_timer.sv
// Down-counting wait timer. A load of W makes the owning state last
// max(W,1) cycles: the state leaves when last is high.
// Assumes: load is asserted on the edge that enters a wait state.
module i2c_eng_timer #(
    parameter int CW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    // Load on state entry, otherwise count toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q <= CW'(1));
endmodule

// File: rtl/i2c_eng_stretch.sv
// Bounded wait on a held SCL. Counts polling cycles since clear and
// reports when the programmed limit is reached.
// Assumes: clear is pulsed on the edge that enters a polling state.
module i2c_eng_stretch #(
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          poll,
    input  logic [LW-1:0] limit,
    output logic          at_limit
);
    logic [LW-1:0] cnt_q;

    assign at_limit = (cnt_q >= limit);

    // Count polling cycles, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (poll && !at_limit)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/i2c_eng_shift.sv
// Byte shifter. Holds the transmit byte (MSB presented first) and
// assembles sampled line levels MSB first. One step per data bit.
// Assumes: load and step are never asserted together.
module i2c_eng_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          step,
    input  logic          sample_bit,
    output logic          tx_bit,
    output logic [DW-1:0] rx_data
);
    logic [DW-1:0] tx_q;
    logic [DW-1:0] rx_q;

    // Transmit register: load a new byte or move to the next bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_q <= '0;
        else if (load)
            tx_q <= load_data;
        else if (step)
            tx_q <= {tx_q[DW-2:0], 1'b0};
    end

    // Receive register: shift in the sampled level on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_q <= '0;
        else if (step)
            rx_q <= {rx_q[DW-2:0], sample_bit};
    end

    assign tx_bit  = tx_q[DW-1];
    assign rx_data = rx_q;
endmodule

// File: rtl/i2c_bit_engine.sv
// I2C master bit engine. Runs one start, stop, byte write or byte read
// per command, driving SCL/SDA through open-drain enables (1 = pull low)
// and reading the true line levels back. Wait phases use D, D+1 or D+2
// cycles; every SCL release waits for SCL high up to stretch_limit.
// Assumes: scl_in/sda_in are synchronous to clk; quarter_dly and
// stretch_limit are stable while a command runs.
module i2c_bit_engine #(
    parameter int DW    = 8,
    parameter int DLY_W = 16,
    parameter int STR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [DW-1:0]    cmd_wdata,
    input  logic             cmd_nack,
    input  logic [DLY_W-1:0] quarter_dly,
    input  logic [STR_W-1:0] stretch_limit,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             idle,
    output logic             done,
    output logic [DW-1:0]    rx_data,
    output logic             ack_level,
    output logic             bus_busy,
    output logic             stretch_tmo
);
    import i2c_eng_pkg::*;

    localparam int TMR_W = DLY_W + 2;
    localparam int IW    = $clog2(DW + 2);
    localparam logic [IW-1:0] ACK_IDX = IW'(DW);

    state_e          state_q, state_d;
    logic            scl_q, scl_d, sda_q, sda_d;
    logic            done_q, done_d;
    logic            err_q, err_d, tmo_q, tmo_d, ack_q, ack_d;
    logic            rd_q, rd_d, nack_q, nack_d;
    logic [IW-1:0]   bit_q, bit_d, bit_nxt;
    logic            tmr_load, tmr_last;
    logic [TMR_W-1:0] tmr_val, dly_w, low_wr, low_rd;
    logic            str_clear, str_poll, str_lim;
    logic            sh_load, sh_step, tx_bit;
    logic            byte_active;

    assign dly_w   = TMR_W'(quarter_dly);
    assign low_wr  = dly_w + TMR_W'(1);
    assign low_rd  = dly_w + TMR_W'(2);
    assign bit_nxt = bit_q + 1'b1;
    assign str_poll = (state_q == ST_B_POLL) || (state_q == ST_P_POLL);
    assign byte_active = (state_q == ST_B_LOW) || (state_q == ST_B_POLL) ||
                         (state_q == ST_B_HIGH);

    i2c_eng_timer #(.CW(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    i2c_eng_stretch #(.LW(STR_W)) u_stretch (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (str_clear),
        .poll     (str_poll),
        .limit    (stretch_limit),
        .at_limit (str_lim)
    );

    i2c_eng_shift #(.DW(DW)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (sh_load),
        .load_data  (cmd_wdata),
        .step       (sh_step),
        .sample_bit (sda_in),
        .tx_bit     (tx_bit),
        .rx_data    (rx_data)
    );

    // Next-state and line-drive decisions for every phase.
    always_comb begin
        state_d   = state_q;
        scl_d     = scl_q;
        sda_d     = sda_q;
        done_d    = 1'b0;
        err_d     = err_q;
        tmo_d     = tmo_q;
        ack_d     = ack_q;
        rd_d      = rd_q;
        nack_d    = nack_q;
        bit_d     = bit_q;
        tmr_load  = 1'b0;
        tmr_val   = dly_w;
        str_clear = 1'b0;
        sh_load   = 1'b0;
        sh_step   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    case (op_e'(cmd_op))
                        OP_START: begin
                            scl_d   = 1'b0;
                            sda_d   = 1'b0;
                            err_d   = 1'b0;
                            state_d = ST_S_REL;
                        end
                        OP_STOP: begin
                            scl_d    = 1'b1;
                            sda_d    = 1'b1;
                            tmr_load = 1'b1;
                            state_d  = ST_P_LOW;
                        end
                        OP_WRITE: begin
                            sh_load  = 1'b1;
                            rd_d     = 1'b0;
                            bit_d    = '0;
                            scl_d    = 1'b1;
                            sda_d    = !cmd_wdata[DW-1];
                            tmr_load = 1'b1;
                            tmr_val  = low_wr;
                            state_d  = ST_B_LOW;
                        end
                        default: begin
                            sh_load  = 1'b1;
                            rd_d     = 1'b1;
                            nack_d   = cmd_nack;
                            bit_d    = '0;
                            scl_d    = 1'b1;
                            sda_d    = 1'b0;
                            tmr_load = 1'b1;
                            tmr_val  = low_rd;
                            state_d  = ST_B_LOW;
                        end
                    endcase
                end
            end
            ST_S_REL: state_d = ST_S_CHK;
            ST_S_CHK: begin
                if (!sda_in) begin
                    err_d   = 1'b1;
                    done_d  = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    tmr_load = 1'b1;
                    state_d  = ST_S_HOLD;
                end
            end
            ST_S_HOLD: begin
                if (tmr_last) begin
                    sda_d    = 1'b1;
                    tmr_load = 1'b1;
                    state_d  = ST_S_FALL;
                end
            end
            ST_S_FALL: begin
                if (tmr_last) begin
                    done_d  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_B_LOW: begin
                if (tmr_last) begin
                    scl_d     = 1'b0;
                    str_clear = 1'b1;
                    state_d   = ST_B_POLL;
                end
            end
            ST_B_POLL: begin
                if (scl_in || str_lim) begin
                    if (!scl_in)
                        tmo_d = 1'b1;
                    if (bit_q == ACK_IDX)
                        ack_d = sda_in;
                    else
                        sh_step = 1'b1;
                    tmr_load = 1'b1;
                    state_d  = ST_B_HIGH;
                end
            end
            ST_B_HIGH: begin
                if (tmr_last) begin
                    if (bit_q == ACK_IDX) begin
                        done_d  = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        bit_d    = bit_nxt;
                        scl_d    = 1'b1;
                        tmr_load = 1'b1;
                        state_d  = ST_B_LOW;
                        if (bit_nxt == ACK_IDX) begin
                            sda_d   = rd_q ? !nack_q : 1'b0;
                            tmr_val = rd_q ? low_wr : low_rd;
                        end else begin
                            sda_d   = rd_q ? 1'b0 : !tx_bit;
                            tmr_val = rd_q ? low_rd : low_wr;
                        end
                    end
                end
            end
            ST_P_LOW: begin
                if (tmr_last) begin
                    scl_d     = 1'b0;
                    str_clear = 1'b1;
                    state_d   = ST_P_POLL;
                end
            end
            ST_P_POLL: begin
                if (scl_in || str_lim) begin
                    if (!scl_in)
                        tmo_d = 1'b1;
                    tmr_load = 1'b1;
                    state_d  = ST_P_HOLD;
                end
            end
            ST_P_HOLD: begin
                if (tmr_last) begin
                    sda_d    = 1'b0;
                    tmr_load = 1'b1;
                    state_d  = ST_P_REL;
                end
            end
            ST_P_REL: begin
                if (tmr_last) begin
                    done_d  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            scl_q   <= 1'b0;
            sda_q   <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            tmo_q   <= 1'b0;
            ack_q   <= 1'b0;
            rd_q    <= 1'b0;
            nack_q  <= 1'b0;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            scl_q   <= scl_d;
            sda_q   <= sda_d;
            done_q  <= done_d;
            err_q   <= err_d;
            tmo_q   <= tmo_d;
            ack_q   <= ack_d;
            rd_q    <= rd_d;
            nack_q  <= nack_d;
            bit_q   <= bit_d;
        end
    end

    assign scl_oe      = scl_q;
    assign sda_oe      = sda_q;
    assign idle        = (state_q == ST_IDLE);
    assign done        = done_q;
    assign ack_level   = ack_q;
    assign bus_busy    = err_q;
    assign stretch_tmo = tmo_q;
endmodule

// File: rtl/i2c_bit_engine_chk.sv
// Protocol checker for the I2C master bit engine, bound to the top.
// Assumes: byte_active is high while a byte command is on the wire.
module i2c_bit_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_oe,
    input logic sda_oe,
    input logic idle,
    input logic done,
    input logic bus_busy,
    input logic stretch_tmo,
    input logic byte_active
);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> idle);

    assert_tmo_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stretch_tmo |=> stretch_tmo);

    assert_busy_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_busy) |-> (!scl_oe && !sda_oe));

    assert_sda_moves_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_active && $changed(sda_oe)) |-> scl_oe);
endmodule

bind i2c_bit_engine i2c_bit_engine_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_oe      (scl_oe),
    .sda_oe      (sda_oe),
    .idle        (idle),
    .done        (done),
    .bus_busy    (bus_busy),
    .stretch_tmo (stretch_tmo),
    .byte_active (byte_active)
);

// File: tb/i2c_bit_engine_test.sv
`timescale 1ns/1ps
module i2c_bit_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [7:0]  cmd_wdata = 8'h00;
    logic        cmd_nack = 1'b0;
    logic [15:0] quarter_dly = 16'd3;
    logic [15:0] stretch_limit = 16'd50;
    logic        scl_oe, sda_oe, idle, done, ack_level, bus_busy, stretch_tmo;
    logic [7:0]  rx_data;

    logic stretch_hold = 1'b0;
    logic sda_hold = 1'b0;
    logic slv_pull;
    logic scl_line, sda_line;

    assign scl_line = !(scl_oe || stretch_hold);
    assign sda_line = !(sda_oe || slv_pull || sda_hold);

    i2c_bit_engine uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_wdata(cmd_wdata), .cmd_nack(cmd_nack), .quarter_dly(quarter_dly),
        .stretch_limit(stretch_limit), .scl_in(scl_line), .sda_in(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .idle(idle), .done(done),
        .rx_data(rx_data), .ack_level(ack_level), .bus_busy(bus_busy),
        .stretch_tmo(stretch_tmo)
    );

    always #4 clk = !clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Slave model: 9-slot pattern, slot k active after the k-th SCL fall.
    logic [8:0] pat = 9'h1FF;
    logic       slv_en = 1'b0;
    int         arm_tok = 0;
    int         seen_tok = 0;
    int         falls = 0;
    logic       scl_prev = 1'b1;

    always @(posedge clk) begin
        scl_prev <= scl_line;
        if (arm_tok != seen_tok) begin
            seen_tok <= arm_tok;
            falls    <= 0;
        end else if (scl_prev && !scl_line) begin
            falls <= falls + 1;
        end
    end

    always_comb begin
        slv_pull = 1'b0;
        if (slv_en && falls >= 1 && falls <= 9)
            slv_pull = !pat[9 - falls];
    end

    // Scoreboard of expected completions.
    typedef struct {
        string      req;
        bit         chk_rx;
        logic [7:0] rx;
        logic       ack;
        logic       err;
    } exp_t;
    exp_t exp_q[$];
    logic exp_err = 1'b0;

    task automatic expect_done(input string req, input bit chk_rx,
                               input logic [7:0] rx, input logic ack);
        exp_t e;
        e.req = req; e.chk_rx = chk_rx; e.rx = rx; e.ack = ack; e.err = exp_err;
        exp_q.push_back(e);
    endtask

    // Monitor: compare each done against the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.chk_rx)
                    chk(rx_data == e.rx, e.req, "rx_data", rx_data, e.rx);
                if (e.chk_rx)
                    chk(ack_level == e.ack, e.req, "ack_level", ack_level, e.ack);
                chk(bus_busy == e.err, "R10", "bus_busy", bus_busy, e.err);
            end
        end
    end

    // Record the length of every SCL low phase driven by the engine.
    int lows[$];
    int run = 0;
    always @(negedge clk) begin
        if (scl_oe) run++;
        else if (run > 0) begin
            lows.push_back(run);
            run = 0;
        end
    end

    // Drive one command; poke_at injects a start while busy, rel_at
    // releases a held SCL. Returns negedges until done is seen.
    task automatic issue(input logic [1:0] op, input logic [7:0] wd,
                         input logic nk, input int poke_at, input int rel_at,
                         output int lat);
        @(negedge clk);
        cmd_op = op; cmd_wdata = wd; cmd_nack = nk; cmd_valid = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (lat == 1) cmd_valid = 1'b0;
            if (poke_at != 0 && lat == poke_at) begin
                cmd_op = 2'b00; cmd_valid = 1'b1;
            end
            if (poke_at != 0 && lat == poke_at + 1) cmd_valid = 1'b0;
            if (rel_at != 0 && lat == rel_at) stretch_hold = 1'b0;
        end while (!done && lat < 5000);
        if (lat >= 5000) chk(1'b0, "R9", "command never completed", lat, 0);
    endtask

    task automatic arm_slave(input logic [8:0] p);
        pat = p; slv_en = 1'b1; arm_tok++;
    endtask

    task automatic check_lows(input string req, input int data_len, input int ack_len);
        chk(lows.size() == 9, req, "number of SCL low phases", lows.size(), 9);
        for (int i = 0; i < lows.size() && i < 9; i++)
            chk(lows[i] == ((i == 8) ? ack_len : data_len), req, "SCL low length",
                lows[i], (i == 8) ? ack_len : data_len);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!scl_oe && !sda_oe, "R1", "lines released", {scl_oe, sda_oe}, 0);
        chk(idle && !done, "R1", "idle/done", {idle, done}, 2);
        chk(!bus_busy && !stretch_tmo, "R1", "flags", {bus_busy, stretch_tmo}, 0);

        // R2 normal start, D=3: done 2D+3 negedges after drive
        exp_err = 1'b0;
        expect_done("R2", 1'b0, 8'h00, 1'b0);
        issue(2'b00, 8'h00, 1'b0, 0, 0, lat);
        chk(lat == 9, "R2", "start latency", lat, 9);
        chk(scl_line && !sda_line, "R2", "start leaves SCL high SDA low",
            {scl_line, sda_line}, 2);

        // R3 write 0xA5, slave acks
        lows.delete();
        arm_slave(9'b1_1111_1110);
        expect_done("R3", 1'b1, 8'hA5, 1'b0);
        issue(2'b10, 8'hA5, 1'b0, 0, 0, lat);
        slv_en = 1'b0;
        check_lows("R3", 4, 5);

        // R3 write 0x3C, slave does not ack
        arm_slave(9'h1FF);
        expect_done("R3", 1'b1, 8'h3C, 1'b1);
        issue(2'b10, 8'h3C, 1'b0, 0, 0, lat);
        slv_en = 1'b0;

        // R4 read 0x96 with master ack
        lows.delete();
        arm_slave({8'h96, 1'b1});
        expect_done("R4", 1'b1, 8'h96, 1'b0);
        issue(2'b11, 8'h00, 1'b0, 0, 0, lat);
        slv_en = 1'b0;
        check_lows("R4", 5, 4);

        // R4 read 0x5A with master nack
        arm_slave({8'h5A, 1'b1});
        expect_done("R4", 1'b1, 8'h5A, 1'b1);
        issue(2'b11, 8'h00, 1'b1, 0, 0, lat);
        slv_en = 1'b0;

        // R9 start command poked while a write runs is ignored
        lows.delete();
        arm_slave(9'b1_1111_1110);
        expect_done("R9", 1'b1, 8'h81, 1'b0);
        issue(2'b10, 8'h81, 1'b0, 6, 0, lat);
        slv_en = 1'b0;
        check_lows("R9", 4, 5);
        repeat (3) @(negedge clk);
        chk(idle && exp_q.size() == 0, "R9", "no extra command ran",
            exp_q.size(), 0);

        // R5 write 0xFF while slave forces bits low: readback 0xF0
        arm_slave({8'hF0, 1'b0});
        expect_done("R5", 1'b1, 8'hF0, 1'b0);
        issue(2'b10, 8'hFF, 1'b0, 0, 0, lat);
        slv_en = 1'b0;

        // R6 stop: done 3D+2 negedges after drive
        expect_done("R6", 1'b0, 8'h00, 1'b0);
        issue(2'b01, 8'h00, 1'b0, 0, 0, lat);
        chk(lat == 11, "R6", "stop latency", lat, 11);
        chk(scl_line && sda_line, "R6", "stop leaves lines high", {scl_line, sda_line}, 3);

        // R2 start with SDA held low: bus busy
        sda_hold = 1'b1;
        exp_err = 1'b1;
        expect_done("R2", 1'b0, 8'h00, 1'b0);
        issue(2'b00, 8'h00, 1'b0, 0, 0, lat);
        chk(lat == 3, "R2", "busy start latency", lat, 3);
        chk(!scl_oe && !sda_oe, "R2", "busy start keeps lines released",
            {scl_oe, sda_oe}, 0);
        sda_hold = 1'b0;

        // R10 stop keeps bus_busy; next start clears it
        expect_done("R10", 1'b0, 8'h00, 1'b0);
        issue(2'b01, 8'h00, 1'b0, 0, 0, lat);
        chk(bus_busy == 1'b1, "R10", "bus_busy held after stop", bus_busy, 1);
        exp_err = 1'b0;
        expect_done("R10", 1'b0, 8'h00, 1'b0);
        issue(2'b00, 8'h00, 1'b0, 0, 0, lat);

        // R3 with D=0: data low 1 cycle, ack slot low 2 cycles
        quarter_dly = 16'd0;
        lows.delete();
        arm_slave(9'b1_1111_1110);
        expect_done("R3", 1'b1, 8'h6B, 1'b0);
        issue(2'b10, 8'h6B, 1'b0, 0, 0, lat);
        slv_en = 1'b0;
        check_lows("R3", 1, 2);
        quarter_dly = 16'd3;

        // R7 short stretch on a stop: released at negedge 20, latency 20+2D+1
        stretch_limit = 16'd100;
        stretch_hold = 1'b1;
        expect_done("R7", 1'b0, 8'h00, 1'b0);
        issue(2'b01, 8'h00, 1'b0, 0, 20, lat);
        chk(lat == 27, "R7", "stretched stop latency", lat, 27);
        chk(stretch_tmo == 1'b0, "R7", "no timeout flag", stretch_tmo, 0);

        // R8 stretch beyond limit 4: latency 3D+6, flag set
        stretch_limit = 16'd4;
        expect_done("R8", 1'b0, 8'h00, 1'b0);
        stretch_hold = 1'b1;
        issue(2'b01, 8'h00, 1'b0, 0, 0, lat);
        stretch_hold = 1'b0;
        chk(lat == 15, "R8", "timed-out stop latency", lat, 15);
        chk(stretch_tmo == 1'b1, "R8", "timeout flag set", stretch_tmo, 1);

        // R8 flag stays set through normal commands
        stretch_limit = 16'd50;
        expect_done("R8", 1'b0, 8'h00, 1'b0);
        issue(2'b00, 8'h00, 1'b0, 0, 0, lat);
        expect_done("R8", 1'b0, 8'h00, 1'b0);
        issue(2'b01, 8'h00, 1'b0, 0, 0, lat);
        chk(stretch_tmo == 1'b1, "R8", "timeout flag sticky", stretch_tmo, 1);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R9", "all completions seen", exp_q.size(), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule